// File: doc/BRIEF.md
# Collision-Arbitrated Dual-Port RAM

This block is a synchronous memory of 8K words by 8 bits with two independent ports, called left and right. Each port has its own chip enable, write enable, address, write data and read data, so two processors can share the storage without a common bus. Reads take one clock cycle. A read that hits the word being written in the same cycle returns the old contents.

An arbiter watches both ports. When both are enabled on the same word in the same cycle, it picks one winner and pulls the other port's active-low busy line low. The losing processor can use that line to stretch its cycle with wait states. While busy is low, a write from the losing port is dropped, so the winner's data stays intact. The losing port's read data is undefined during that time.

The winner is chosen as follows. A port that was already on the word, with its enable held and its address unchanged from the previous cycle, keeps it. If both ports arrive on the word in the same cycle, the left port wins. Busy stays low for as long as the winner remains enabled on that word. It releases in the first cycle in which the two ports no longer address the same word.

Top module: `dpr_collide_ram`

## Requirements
- R1: While reset is high, both busy outputs read 1. The first contention after reset is treated as a simultaneous arrival: the left port wins and `r_busy_n` goes low.
- R2: A write on an enabled port stores the data. A read returns the word at the address presented at the previous rising edge. A read of a word written in the same cycle returns the old contents. Read data holds while the port's enable is low.
- R3: Both busy outputs are 1 in every cycle in which at least one enable is low, or the two addresses differ.
- R4: When both ports become enabled on the same word in the same cycle, `r_busy_n` is 0 and `l_busy_n` is 1.
- R5: When the right port was enabled on a word in the previous cycle without losing, and is still on it, a left access to that word drives `l_busy_n` to 0 and leaves `r_busy_n` at 1.
- R6: Busy stays low on the losing port for as long as both ports stay enabled on the same word. It returns to 1 in the first cycle in which the winner drops its enable or changes address.
- R7: A write from a port whose busy output is 0 does not change memory. The winner's write in that cycle is stored.
- R8: A port that lost and stays on the word becomes its holder once the winner has left. If the former winner then returns to that word, the former winner is the one that gets busy.
- R9: The two ports can write different words in the same cycle, including the words at address 0 and address 8191, and both writes are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left port write enable |
| l_addr | input | 13 | Left port word address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port read data, one cycle latency |
| l_busy_n | output | 1 | Left port wait request, active low |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right port write enable |
| r_addr | input | 13 | Right port word address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port read data, one cycle latency |
| r_busy_n | output | 1 | Right port wait request, active low |

## Verification
The hardest case to reach is an ownership hand-off. The loser must stay parked on a contended word until the winner leaves, and then hold the word against the returning former winner. This needs several cycles of coordinated enables and addresses, which uniform random addresses almost never produce. Directed sequences therefore build the hand-off step by step. The random phase draws both addresses from a four-word pool and keeps the enables high most of the time, so that contention, holding and release occur often. Every cycle is compared against a reference model in the bench that tracks the holder of the word and the memory contents.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_L    = 2'd1,
        SIDE_R    = 2'd2
    } side_e;

    typedef struct packed {
        logic  ce;
        logic  we;
        addr_t addr;
        data_t wdata;
    } port_req_t;

    function automatic logic same_word(input port_req_t a, input port_req_t b);
        return a.ce && b.ce && (a.addr == b.addr);
    endfunction

    // a port is incumbent when it held its word last cycle and has not moved
    function automatic logic incumbent(input logic held, input addr_t prev, input port_req_t p);
        return held && p.ce && (p.addr == prev);
    endfunction

endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
    import dpr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_req_t req_l,
    input  port_req_t req_r,
    output side_e     loser,
    output logic      busy_l_n,
    output logic      busy_r_n
);

    logic  hold_l, hold_r;
    addr_t prev_l, prev_r;
    logic  hit, inc_l, inc_r, right_wins;

    always_comb begin
        hit        = same_word(req_l, req_r);
        inc_l      = incumbent(hold_l, prev_l, req_l);
        inc_r      = incumbent(hold_r, prev_r, req_r);
        right_wins = inc_r && !inc_l;
        if (rst || !hit)
            loser = SIDE_NONE;
        else if (right_wins)
            loser = SIDE_L;
        else
            loser = SIDE_R;
        busy_l_n = (loser != SIDE_L);
        busy_r_n = (loser != SIDE_R);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_l <= 1'b0;
            hold_r <= 1'b0;
            prev_l <= '0;
            prev_r <= '0;
        end else begin
            hold_l <= req_l.ce && (loser != SIDE_L);
            hold_r <= req_r.ce && (loser != SIDE_R);
            prev_l <= req_l.addr;
            prev_r <= req_r.addr;
        end
    end

endmodule

// File: rtl/dpr_storage.sv
module dpr_storage
    import dpr_pkg::*;
(
    input  logic  clk,
    input  logic  en_l,
    input  logic  wr_l,
    input  addr_t addr_l,
    input  data_t wd_l,
    output data_t rd_l,
    input  logic  en_r,
    input  logic  wr_r,
    input  addr_t addr_r,
    input  data_t wd_r,
    output data_t rd_r
);

    data_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_l) mem[addr_l] <= wd_l;
        if (wr_r) mem[addr_r] <= wd_r;
    end

    always_ff @(posedge clk) begin
        if (en_l) rd_l <= mem[addr_l];
        if (en_r) rd_r <= mem[addr_r];
    end

endmodule

// File: rtl/dpr_collide_ram.sv
module dpr_collide_ram
    import dpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              l_ce,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_busy_n,
    input  logic              r_ce,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_busy_n
);

    port_req_t req_l, req_r;
    side_e     loser;
    logic      wr_l, wr_r;

    assign req_l = '{ce: l_ce, we: l_we, addr: l_addr, wdata: l_wdata};
    assign req_r = '{ce: r_ce, we: r_we, addr: r_addr, wdata: r_wdata};

    dpr_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .req_l    (req_l),
        .req_r    (req_r),
        .loser    (loser),
        .busy_l_n (l_busy_n),
        .busy_r_n (r_busy_n)
    );

    // the losing side's write is dropped
    assign wr_l = !rst && req_l.ce && req_l.we && (loser != SIDE_L);
    assign wr_r = !rst && req_r.ce && req_r.we && (loser != SIDE_R);

    dpr_storage u_mem (
        .clk    (clk),
        .en_l   (req_l.ce),
        .wr_l   (wr_l),
        .addr_l (req_l.addr),
        .wd_l   (req_l.wdata),
        .rd_l   (l_rdata),
        .en_r   (req_r.ce),
        .wr_r   (wr_r),
        .addr_r (req_r.addr),
        .wd_r   (req_r.wdata),
        .rd_r   (r_rdata)
    );

endmodule

// File: rtl/dpr_chk.sv
module dpr_chk
    import dpr_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  l_ce,
    input addr_t l_addr,
    input logic  l_busy_n,
    input logic  r_ce,
    input addr_t r_addr,
    input logic  r_busy_n
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |-> (l_busy_n && r_busy_n));

    // R3
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !(l_ce && r_ce && (l_addr == r_addr)) |-> (l_busy_n && r_busy_n));

    // R4
    fresh_tie_chk: assert property (@(posedge clk) disable iff (rst)
        (l_ce && r_ce && (l_addr == r_addr) && !$past(l_ce) && !$past(r_ce))
            |-> (!r_busy_n && l_busy_n));

    // R5
    single_loser_chk: assert property (@(posedge clk) disable iff (rst)
        !(!l_busy_n && !r_busy_n));

    // R6
    hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !r_busy_n |=> (!(l_ce && r_ce && $stable(l_addr) && $stable(r_addr)) || !r_busy_n));

endmodule

bind dpr_collide_ram dpr_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .l_ce     (l_ce),
    .l_addr   (l_addr),
    .l_busy_n (l_busy_n),
    .r_ce     (r_ce),
    .r_addr   (r_addr),
    .r_busy_n (r_busy_n)
);

// File: tb/sim_dpr_collide_ram.sv
module sim_dpr_collide_ram;
    import dpr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
    addr_t       l_addr = '0, r_addr = '0;
    data_t       l_wdata = '0, r_wdata = '0;
    data_t       l_rdata, r_rdata;
    logic        l_busy_n, r_busy_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic done = 1'b0;

    // reference model
    data_t m_mem [DEPTH];
    logic  m_hold_l = 0, m_hold_r = 0;
    addr_t m_prev_l = '0, m_prev_r = '0;
    data_t m_rd_l = '0, m_rd_r = '0;
    logic  m_rdv_l = 0, m_rdv_r = 0;

    dpr_collide_ram u0 (
        .clk(clk), .rst(rst),
        .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_busy_n(l_busy_n),
        .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_busy_n(r_busy_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycles %0d expected < %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // expected loser: 0 none, 1 left, 2 right
    function automatic int exp_loser(input logic cl, input addr_t al, input logic cr, input addr_t ar);
        logic il, ir;
        if (!(cl && cr && al == ar)) return 0;
        il = m_hold_l && (al == m_prev_l);
        ir = m_hold_r && (ar == m_prev_r);
        return (ir && !il) ? 1 : 2;
    endfunction

    // one clock cycle of stimulus with checks on busy and read data
    task automatic step(input string tag,
                        input logic cl, input logic wl, input addr_t al, input data_t dl,
                        input logic cr, input logic wr, input addr_t ar, input data_t dr);
        int lz;
        @(negedge clk);
        l_ce = cl; l_we = wl; l_addr = al; l_wdata = dl;
        r_ce = cr; r_we = wr; r_addr = ar; r_wdata = dr;
        #1;
        lz = exp_loser(cl, al, cr, ar);
        check({tag, " busy_l"}, l_busy_n, lz != 1);
        check({tag, " busy_r"}, r_busy_n, lz != 2);
        // read-first expectations
        if (cl) begin m_rd_l = m_mem[al]; m_rdv_l = (lz != 1); end
        if (cr) begin m_rd_r = m_mem[ar]; m_rdv_r = (lz != 2); end
        if (cl && wl && lz != 1) m_mem[al] = dl;
        if (cr && wr && lz != 2) m_mem[ar] = dr;
        m_hold_l = cl && (lz != 1);
        m_hold_r = cr && (lz != 2);
        m_prev_l = al;
        m_prev_r = ar;
        @(posedge clk);
        #1;
        if (m_rdv_l) check({tag, " rdata_l"}, l_rdata, m_rd_l);
        if (m_rdv_r) check({tag, " rdata_r"}, r_rdata, m_rd_r);
    endtask

    task automatic idle();
        step("idle R3", 0, 0, '0, '0, 0, 0, '0, '0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        // R1: reset state; clear memory through the ports with reset held low later
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset busy_l", l_busy_n, 1);
        check("R1 reset busy_r", r_busy_n, 1);
        @(negedge clk);
        rst = 1'b0;
        // fill memory with zeros so the model is defined
        for (int a = 0; a < DEPTH; a += 2)
            step("R9 init", 1, 1, addr_t'(a), 8'h00, 1, 1, addr_t'(a + 1), 8'h00);
        // R1: first tie after reset, left wins
        idle();
        step("R1 R4 first tie", 1, 1, 13'd5, 8'hA5, 1, 1, 13'd5, 8'h5A);
        step("R6 hold", 1, 0, 13'd5, 8'h00, 1, 1, 13'd5, 8'h77);
        idle();
        // R7: the losing write did not land
        step("R7 readback", 1, 0, 13'd5, 8'h00, 0, 0, '0, '0);
        check("R7 word kept", l_rdata, 8'hA5);
        // R5: right already holds the word, left arrives
        step("R5 right first", 0, 0, '0, '0, 1, 1, 13'd9, 8'h39);
        step("R5 left arrives", 1, 1, 13'd9, 8'hEE, 1, 0, 13'd9, 8'h00);
        check("R5 busy_l low", l_busy_n, 0);
        step("R6 still held", 1, 1, 13'd9, 8'hEF, 1, 0, 13'd9, 8'h00);
        // R6: right leaves, busy releases the same cycle
        step("R6 release", 1, 0, 13'd9, 8'h00, 0, 0, '0, '0);
        check("R6 busy_l back", l_busy_n, 1);
        // R8: left now holds; right returns and loses
        step("R8 right returns", 1, 0, 13'd9, 8'h00, 1, 1, 13'd9, 8'h11);
        check("R8 busy_r low", r_busy_n, 0);
        // R6: winner moves address, release
        step("R6 move", 1, 0, 13'd10, 8'h00, 1, 0, 13'd9, 8'h00);
        idle();
        // R9: boundary words written in the same cycle
        step("R9 edges", 1, 1, 13'd0, 8'h3C, 1, 1, 13'd8191, 8'hC3);
        step("R9 read", 1, 0, 13'd8191, 8'h00, 1, 0, 13'd0, 8'h00);
        check("R9 l top", l_rdata, 8'hC3);
        check("R9 r bottom", r_rdata, 8'h3C);
        // R2: hold while disabled
        idle();
        check("R2 hold l", l_rdata, 8'hC3);
        // random phase, R2..R8 against the model
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] pl, pr;
            pl = 2'($urandom_range(0, 3));
            pr = 2'($urandom_range(0, 3));
            step("rand R2 R3 R6 R7 R8",
                 $urandom_range(0, 9) < 8, 1'($urandom), addr_t'(8188 + pl), 8'($urandom),
                 $urandom_range(0, 9) < 8, 1'($urandom), addr_t'(8188 + pr), 8'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule